// File: doc/BRIEF.md
# Saturating narrowing vector shifter

This unit takes two 256-bit vector operands and a mode, and returns one 256-bit result. Every wide element of the first operand is shifted right by the count held in the same-position element of the second operand. The shifted value is then clamped to a signed or unsigned range of half the element width, and the half-width value is kept. Three source element sizes are supported: 16, 32 and 64 bits, which give 8, 16 and 32-bit results.

The vector is split into 128-bit lanes, and each lane is handled on its own. The narrowed values of a lane are packed in element order into the lower 64 bits of that lane, and the upper 64 bits of the lane are cleared. A start strobe loads the operation. The packed result and a one-cycle valid pulse appear on the next clock. The result is held until the next start.

Top module: `vnarrow_sat_shr`

## Requirements
- R1: With size code 00, each 16-bit source element is narrowed to 8 bits. The byte from element j of a lane sits at bits 8j+7:8j of that lane.
- R2: With size code 01, each 32-bit element is narrowed to 16 bits and packed in element order into the lower 64 bits of its lane.
- R3: With size code 10, each 64-bit element is narrowed to 32 bits and packed in element order into the lower 64 bits of its lane.
- R4: The shift count is the matching element of the second operand, read as unsigned. Only its value modulo the source element width is used, so higher count bits have no effect.
- R5: With arith_i=0 and usat_i=0 (logical shift, signed clamp), a shifted value that is above 2^(h-1)-1 when read as unsigned gives 2^(h-1)-1, where h is the narrow width.
- R6: With arith_i=1 and usat_i=0 (arithmetic shift, signed clamp), values above 2^(h-1)-1 give 2^(h-1)-1, and values below -2^(h-1) give -2^(h-1). Values in between pass unchanged.
- R7: With arith_i=0 and usat_i=1 (logical shift, unsigned clamp), values above 2^h-1 give 2^h-1.
- R8: With arith_i=1 and usat_i=1, a source element with its top bit set gives 0. Any other element is shifted and clamped to 2^h-1.
- R9: Each 128-bit lane uses only its own operand bits. Bits 127:64 of every lane in the result are zero.
- R10: A shift count of zero passes the element unchanged into the clamp, so an in-range value comes out as its own low half.
- R11: Size code 11 gives an all-zero result.
- R12: valid_o is high exactly in the cycle after a cycle with start_i high. res_o changes only after a start.
- R13: While rst_n is low, valid_o and res_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads the operation present on the inputs |
| size_i | input | 2 | Source element size: 00=16, 01=32, 10=64, 11=illegal |
| arith_i | input | 1 | 1 = arithmetic right shift, 0 = logical |
| usat_i | input | 1 | 1 = unsigned clamp, 0 = signed clamp |
| src_a_i | input | 256 | Elements to be shifted |
| src_b_i | input | 256 | Per-element shift counts |
| res_o | output | 256 | Packed narrowed result |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The assertions assume that start_i, size_i, arith_i and usat_i hold known values at every rising edge once reset is released. They also assume the operands are stable across the edge at which start_i is sampled, since the clamp properties relate the operands seen with a start to the result one cycle later. The bench changes every input only on the falling edge, so each input is settled half a period before it is sampled. Between starts the bench changes the operands on purpose, to show that the held result does not follow them.

// File: rtl/vns_pkg.sv
package vns_pkg;

  // Source element size selector
  typedef enum logic [1:0] {
    SZ_H16  = 2'b00,
    SZ_W32  = 2'b01,
    SZ_D64  = 2'b10,
    SZ_NONE = 2'b11
  } size_code_e;

  localparam int unsigned LANE_BITS = 128;
  localparam int unsigned NUM_SIZES = 3;

  // Source element width for a given size index
  function automatic int unsigned elem_width(input int unsigned idx);
    return 16 << idx;
  endfunction

endpackage

// File: rtl/vns_shift.sv
// Variable right shift of one wide element, logical or arithmetic.
module vns_shift #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] cnt_i,
  input  logic         arith_i,
  output logic [W-1:0] sh_o
);
  localparam int unsigned SW = $clog2(W);

  logic [SW-1:0] amt;

  always_comb begin
    // count taken modulo the element width
    amt = cnt_i[SW-1:0];
    if (arith_i) begin
      sh_o = $unsigned($signed(val_i) >>> amt);
    end else begin
      sh_o = val_i >> amt;
    end
  end
endmodule

// File: rtl/vns_sat.sv
// Clamp a shifted wide value to half width, signed or unsigned.
module vns_sat #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   sh_i,
  input  logic           neg_i,
  input  logic           arith_i,
  input  logic           usat_i,
  output logic [W/2-1:0] nar_o
);
  localparam int unsigned H = W / 2;
  localparam logic [W-1:0] SMAX = W'((64'd1 << (H - 1)) - 64'd1);
  localparam logic [W-1:0] SMIN = ~SMAX;
  localparam logic [W-1:0] UMAX = W'((64'd1 << H) - 64'd1);

  logic over_s;
  logic under_s;
  logic over_u;

  always_comb begin
    over_s  = $signed(sh_i) > $signed(SMAX);
    under_s = $signed(sh_i) < $signed(SMIN);
    over_u  = sh_i > UMAX;
    nar_o   = sh_i[H-1:0];
    if (usat_i) begin
      if (arith_i && neg_i) begin
        nar_o = '0;
      end else if (over_u) begin
        nar_o = UMAX[H-1:0];
      end
    end else if (arith_i) begin
      if (over_s) begin
        nar_o = SMAX[H-1:0];
      end else if (under_s) begin
        nar_o = SMIN[H-1:0];
      end
    end else if (sh_i > SMAX) begin
      nar_o = SMAX[H-1:0];
    end
  end
endmodule

// File: rtl/vns_lane.sv
// One 128-bit lane: a datapath per element size, then a size select.
module vns_lane
  import vns_pkg::*;
#(
  parameter int unsigned LW = LANE_BITS
) (
  input  logic [LW-1:0] a_i,
  input  logic [LW-1:0] b_i,
  input  size_code_e    size_i,
  input  logic          arith_i,
  input  logic          usat_i,
  output logic [LW-1:0] lane_o
);
  localparam int unsigned HALF = LW / 2;

  logic [HALF-1:0] packed_v [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int unsigned W = elem_width(s);
    localparam int unsigned H = W / 2;
    localparam int unsigned N = LW / W;

    logic [HALF-1:0] part;

    for (genvar e = 0; e < N; e++) begin : g_elem
      logic [W-1:0] shv;

      vns_shift #(.W(W)) u_shift (
        .val_i   (a_i[e*W +: W]),
        .cnt_i   (b_i[e*W +: W]),
        .arith_i (arith_i),
        .sh_o    (shv)
      );

      vns_sat #(.W(W)) u_sat (
        .sh_i    (shv),
        .neg_i   (a_i[e*W + W - 1]),
        .arith_i (arith_i),
        .usat_i  (usat_i),
        .nar_o   (part[e*H +: H])
      );
    end

    assign packed_v[s] = part;
  end

  always_comb begin
    lane_o = '0;
    case (size_i)
      SZ_H16:  lane_o[HALF-1:0] = packed_v[0];
      SZ_W32:  lane_o[HALF-1:0] = packed_v[1];
      SZ_D64:  lane_o[HALF-1:0] = packed_v[2];
      default: lane_o = '0;
    endcase
  end
endmodule

// File: rtl/vnarrow_sat_shr.sv
// Saturating narrowing right shifter over a multi-lane vector.
module vnarrow_sat_shr
  import vns_pkg::*;
#(
  parameter int unsigned VW = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    size_i,
  input  logic          arith_i,
  input  logic          usat_i,
  input  logic [VW-1:0] src_a_i,
  input  logic [VW-1:0] src_b_i,
  output logic [VW-1:0] res_o,
  output logic          valid_o
);
  localparam int unsigned NLANE = VW / LANE_BITS;

  size_code_e    size_sel;
  logic [VW-1:0] calc;
  logic [VW-1:0] res_d;
  logic [VW-1:0] res_q;
  logic          valid_d;
  logic          valid_q;
  logic          ld_en;

  assign size_sel = size_code_e'(size_i);

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    vns_lane #(.LW(LANE_BITS)) u_lane (
      .a_i     (src_a_i[l*LANE_BITS +: LANE_BITS]),
      .b_i     (src_b_i[l*LANE_BITS +: LANE_BITS]),
      .size_i  (size_sel),
      .arith_i (arith_i),
      .usat_i  (usat_i),
      .lane_o  (calc[l*LANE_BITS +: LANE_BITS])
    );
  end

  // next-state
  always_comb begin
    ld_en   = start_i;
    res_d   = calc;
    valid_d = start_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (ld_en) begin
        res_q <= res_d;
      end
    end
  end

  assign res_o   = res_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/vns_chk.sv
// Property checker bound to the shifter top.
module vns_chk #(
  parameter int unsigned VW = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [1:0]    size_i,
  input logic          arith_i,
  input logic          usat_i,
  input logic [VW-1:0] src_a_i,
  input logic [VW-1:0] res_o,
  input logic          valid_o
);
  localparam int unsigned NL = VW / 128;

  // R12
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o);

  // R12
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !valid_o);

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(res_o));

  // R11
  bad_size_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && size_i == 2'b11) |=> (res_o == '0));

  // R8
  uns_arith_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && size_i == 2'b10 && arith_i && usat_i && src_a_i[63])
      |=> (res_o[31:0] == 32'h0));

  for (genvar l = 0; l < NL; l++) begin : g_up
    // R9
    upper_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (res_o[l*128 + 64 +: 64] == 64'h0));
  end
endmodule

bind vnarrow_sat_shr vns_chk #(.VW(VW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .size_i  (size_i),
  .arith_i (arith_i),
  .usat_i  (usat_i),
  .src_a_i (src_a_i),
  .res_o   (res_o),
  .valid_o (valid_o)
);

// File: tb/sim_vnarrow_sat_shr.sv
`timescale 1ns/1ps
module sim_vnarrow_sat_shr;
  logic         clk;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   size_i;
  logic         arith_i;
  logic         usat_i;
  logic [255:0] src_a_i;
  logic [255:0] src_b_i;
  logic [255:0] res_o;
  logic         valid_o;

  int nchk = 0;
  int nerr = 0;

  vnarrow_sat_shr u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
    .arith_i(arith_i), .usat_i(usat_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .res_o(res_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // entry: {req, size, arith, usat, element, count, expected narrow}
  localparam int NV = 22;
  localparam logic [167:0] TBL [NV] = '{
    {4'd1,  2'd0, 1'b0, 1'b0, 64'h0100,              64'd4,      32'h10},        // R1
    {4'd5,  2'd0, 1'b0, 1'b0, 64'h8000,              64'd0,      32'h7F},        // R5 R10
    {4'd5,  2'd0, 1'b0, 1'b0, 64'hFF00,              64'd8,      32'h7F},        // R5
    {4'd6,  2'd0, 1'b1, 1'b0, 64'hFF00,              64'd4,      32'hF0},        // R6
    {4'd6,  2'd0, 1'b1, 1'b0, 64'h8000,              64'd1,      32'h80},        // R6
    {4'd6,  2'd0, 1'b1, 1'b0, 64'h7FFF,              64'd2,      32'h7F},        // R6
    {4'd7,  2'd0, 1'b0, 1'b1, 64'hFF00,              64'd4,      32'hFF},        // R7
    {4'd4,  2'd0, 1'b0, 1'b1, 64'h0ABC,              64'd20,     32'hAB},        // R4
    {4'd8,  2'd0, 1'b1, 1'b1, 64'h8000,              64'd15,     32'h00},        // R8
    {4'd8,  2'd0, 1'b1, 1'b1, 64'h0F00,              64'd4,      32'hF0},        // R8
    {4'd4,  2'd0, 1'b1, 1'b0, 64'h0040,              64'hFFF3,   32'h08},        // R4
    {4'd2,  2'd1, 1'b0, 1'b0, 64'h0012_3400,         64'd8,      32'h1234},      // R2
    {4'd10, 2'd1, 1'b1, 1'b0, 64'hFFFF_8000,         64'd0,      32'h8000},      // R10 R6
    {4'd6,  2'd1, 1'b1, 1'b0, 64'hFFFE_0000,         64'd1,      32'h8000},      // R6
    {4'd7,  2'd1, 1'b0, 1'b1, 64'h8000_0000,         64'd47,     32'hFFFF},      // R7 R4
    {4'd8,  2'd1, 1'b1, 1'b1, 64'h0001_2345,         64'd4,      32'h1234},      // R8
    {4'd3,  2'd2, 1'b0, 1'b0, 64'h0000_0001_0000_0000, 64'd2,    32'h4000_0000}, // R3
    {4'd6,  2'd2, 1'b1, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'd1,    32'h8000_0000}, // R6 R3
    {4'd8,  2'd2, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'd0,    32'h0},         // R8
    {4'd4,  2'd2, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd96,   32'hFFFF_FFFF}, // R4 R7
    {4'd10, 2'd2, 1'b0, 1'b0, 64'h0000_0000_7FFF_FFFF, 64'd0,    32'h7FFF_FFFF}, // R10
    {4'd11, 2'd3, 1'b0, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'd3,    32'h1234}       // R11
  };

  function automatic logic [255:0] rep_src(input logic [63:0] e, input logic [1:0] sz);
    logic [255:0] r;
    int w;
    w = (sz == 2'd3) ? 64 : (16 << sz);
    for (int i = 0; i < 256; i++) r[i] = e[i % w];
    return r;
  endfunction

  function automatic logic [255:0] rep_exp(input logic [31:0] x, input logic [1:0] sz);
    logic [255:0] r;
    int h;
    r = '0;
    if (sz != 2'd3) begin
      h = 8 << sz;
      for (int l = 0; l < 2; l++)
        for (int i = 0; i < 64; i++) r[l*128 + i] = x[i % h];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // drive at falling edge, result sampled at the following falling edge
  task automatic issue(input logic [1:0] sz, input logic ar, input logic us,
                       input logic [255:0] a, input logic [255:0] b);
    @(negedge clk);
    size_i = sz; arith_i = ar; usat_i = us; src_a_i = a; src_b_i = b;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    logic [255:0] a;
    logic [255:0] e;
    logic [255:0] held;
    rst_n = 1'b0; start_i = 1'b0; size_i = 2'd0; arith_i = 1'b0; usat_i = 1'b0;
    src_a_i = '0; src_b_i = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    check_bit("R13 valid in reset", valid_o, 1'b0);
    check("R13 result in reset", res_o, '0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [167:0] t;
      t = TBL[k];
      issue(t[163:162], t[161], t[160], rep_src(t[159:96], t[163:162]),
            rep_src(t[95:32], t[163:162]));
      check_bit($sformatf("R12 valid vector %0d", k), valid_o, 1'b1);
      check($sformatf("R%0d vector %0d", t[167:164], k), res_o,
            rep_exp(t[31:0], t[163:162]));
    end

    // R1 R9: element order within lanes, distinct per lane, zero count
    a = '0; e = '0;
    for (int i = 0; i < 16; i++) begin
      a[i*16 +: 16] = 16'(i * 16);
      e[(i / 8) * 128 + (i % 8) * 8 +: 8] = 8'(i * 16);
    end
    issue(2'd0, 1'b0, 1'b1, a, '0);
    check("R1 R9 element order per lane", res_o, e);

    // R9: lanes see only their own operands
    a = '0; e = '0;
    for (int i = 0; i < 8; i++) begin
      a[i*16 +: 16]       = 16'h0100;
      a[128 + i*16 +: 16] = 16'h0200;
      e[i*8 +: 8]         = 8'h10;
      e[128 + i*8 +: 8]   = 8'h20;
    end
    issue(2'd0, 1'b0, 1'b0, a, rep_src(64'd4, 2'd0));
    check("R9 lane independence", res_o, e);
    held = res_o;

    // R12: new operands without start leave the result and drop valid
    src_a_i = '1; src_b_i = '0; size_i = 2'd2;
    @(negedge clk);
    check_bit("R12 valid low without start", valid_o, 1'b0);
    check("R12 result held without start", res_o, held);

    // R13: reset mid-run clears the outputs
    issue(2'd1, 1'b0, 1'b0, rep_src(64'h0012_3400, 2'd1), rep_src(64'd8, 2'd1));
    rst_n = 1'b0;
    #1;
    check_bit("R13 valid after reset", valid_o, 1'b0);
    check("R13 result after reset", res_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule